// File: doc/BRIEF.md
# Audio Sample Byte-Order and User-Bit Formatter

This block sits between the bus side, which delivers 24-bit audio samples, and the transmitter's line encoder. Each accepted sample is rearranged byte by byte according to a two-bit order setting and held in one output register. The register takes part in a valid/ready exchange on both sides, so backpressure from the encoder reaches the bus side.

For each subframe the block also supplies one user-data bit. A select input picks the source. One source is a 96-bit bank made of three 32-bit words, sent in sequence. The other is bit 23 of the sample being presented. A bit position counter moves only when the encoder strobes a subframe advance. When the last of the 96 positions has been consumed, the block raises a single-cycle completion pulse.

Top module: `audio_sample_formatter`

## Requirements
- R1: While `srst` is high at a rising edge, the next state has `out_valid` = 0, `ud_done` = 0 and the user-bit position = 0; `in_ready` is 1 while `out_valid` is 0.
- R2: With `swap_mode` = 2'b00, the captured sample equals the input sample unchanged.
- R3: With `swap_mode` = 2'b01, the captured sample also equals the input sample unchanged.
- R4: With `swap_mode` = 2'b10, the captured sample is `{in[7:0], in[15:8], in[23:16]}`.
- R5: With `swap_mode` = 2'b11, the captured sample is `{8'h00, in[7:0], in[15:8]}`.
- R6: A sample accepted at an edge (`in_valid` and `in_ready` both high) appears on `out_sample` with `out_valid` high right after that edge.
- R7: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_sample` hold across the edge.
- R8: With `user_sel` = 0, `out_user` is bit p of the 96-bit bank `{user_w2, user_w1, user_w0}`, where p is the current position. The bank is therefore sent from `user_w0` bit 0 up to `user_w2` bit 31.
- R9: With `user_sel` = 1, `out_user` equals bit 23 of the sample as it arrived, before reordering, for the sample currently on the output.
- R10: The position rises by one at each edge where `sf_advance` is high, goes from 95 back to 0, and stays put otherwise.
- R11: `ud_done` is high for exactly the one cycle after the edge at which `sf_advance` consumed position 95. It pulses in either `user_sel` setting.
- R12: A synchronous reset in the middle of the sequence returns the position to 0, so the next user bit is `user_w0` bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| swap_mode | input | 2 | Byte order setting applied when a sample is accepted |
| user_sel | input | 1 | User-bit source: 0 = 96-bit bank, 1 = sample bit 23 |
| user_w0 | input | 32 | First bank word, positions 0 to 31 |
| user_w1 | input | 32 | Second bank word, positions 32 to 63 |
| user_w2 | input | 32 | Third bank word, positions 64 to 95 |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted when high with in_valid |
| in_sample | input | 24 | Raw sample from the bus side |
| out_valid | output | 1 | Formatted sample valid |
| out_ready | input | 1 | Encoder takes the formatted sample |
| out_sample | output | 24 | Formatted sample |
| out_user | output | 1 | User-data bit for the current subframe |
| sf_advance | input | 1 | Subframe advance strobe from the encoder |
| ud_done | output | 1 | One-cycle pulse after the 96th user bit |

## Verification
The assertions assume that `srst` is held high from time zero until the first edges. They also assume that `sf_advance` is a clean level sampled at the clock, which may stay high for consecutive cycles. The checks do not depend on `in_valid` staying high while the output stalls, so the stimulus raises and drops `in_valid`, `out_ready` and `sf_advance` at random from a fixed seed. All inputs change away from the rising edge. A reset pulse in the middle of the run and an early stretch of back-to-back advances reach the wrap at position 95 and the restart at position 0.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
    localparam int unsigned SMP_W   = 24;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned SMP_NB  = SMP_W / BYTE_W;

    typedef enum logic [1:0] {
        ORD_PASS     = 2'b00,
        ORD_PASS_ALT = 2'b01,
        ORD_REV_ALL  = 2'b10,
        ORD_REV_LOW  = 2'b11
    } byte_order_e;

    typedef struct packed {
        logic             valid;
        logic [SMP_W-1:0] sample;
        logic             top_bit;
    } stage_state_t;
endpackage

// File: rtl/fmt_byte_swap.sv
module fmt_byte_swap
    import fmt_pkg::*;
(
    input  logic [1:0]       order,
    input  logic [SMP_W-1:0] raw,
    output logic [SMP_W-1:0] swapped
);
    localparam int unsigned NB = SMP_NB;

    logic [SMP_W-1:0] rev_all;
    logic [SMP_W-1:0] rev_low;

    for (genvar k = 0; k < NB; k++) begin : g_rev_all
        assign rev_all[k*BYTE_W +: BYTE_W] = raw[(NB-1-k)*BYTE_W +: BYTE_W];
    end

    for (genvar k = 0; k < NB; k++) begin : g_rev_low
        if (k == NB-1) begin : g_top
            assign rev_low[k*BYTE_W +: BYTE_W] = '0;
        end else begin : g_body
            assign rev_low[k*BYTE_W +: BYTE_W] = raw[(NB-2-k)*BYTE_W +: BYTE_W];
        end
    end

    always_comb begin
        unique case (byte_order_e'(order))
            ORD_REV_ALL: swapped = rev_all;
            ORD_REV_LOW: swapped = rev_low;
            default:     swapped = raw;
        endcase
    end

    always_comb begin
        if (order == 2'b11) begin
            a_zero_top_r5: assert (swapped[SMP_W-1 -: BYTE_W] == '0);
        end
    end
endmodule

// File: rtl/fmt_sample_stage.sv
module fmt_sample_stage
    import fmt_pkg::*;
(
    input  logic             clk,
    input  logic             srst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [SMP_W-1:0] fmt_sample,
    input  logic             raw_top,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [SMP_W-1:0] out_sample,
    output logic             out_top
);
    stage_state_t st_d, st_q;
    logic         take;

    assign in_ready = !st_q.valid || out_ready;
    assign take     = in_valid && in_ready;

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.valid   = 1'b1;
            st_d.sample  = fmt_sample;
            st_d.top_bit = raw_top;
        end else if (out_ready) begin
            st_d.valid = 1'b0;
        end
        if (srst) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign out_valid  = st_q.valid;
    assign out_sample = st_q.sample;
    assign out_top    = st_q.top_bit;

    p_hold_r7: assert property (@(posedge clk) disable iff (srst)
        (!srst && out_valid && !out_ready) |=> (out_valid && $stable(out_sample)));
    p_accept_r6: assert property (@(posedge clk) disable iff (srst)
        (!srst && in_valid && in_ready) |=> out_valid);
    p_reset_r1: assert property (@(posedge clk)
        srst |=> !out_valid);
endmodule

// File: rtl/fmt_user_seq.sv
module fmt_user_seq #(
    parameter int unsigned WORD_W  = 32,
    parameter int unsigned N_WORDS = 3
) (
    input  logic                      clk,
    input  logic                      srst,
    input  logic [N_WORDS*WORD_W-1:0] bank,
    input  logic                      advance,
    output logic                      bank_bit,
    output logic                      done
);
    localparam int unsigned TOTAL = N_WORDS * WORD_W;
    localparam int unsigned IDX_W = $clog2(TOTAL);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(TOTAL - 1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             done;
    } seq_state_t;

    seq_state_t sq_d, sq_q;

    always_comb begin
        sq_d      = sq_q;
        sq_d.done = 1'b0;
        if (advance) begin
            sq_d.done = (sq_q.idx == LAST);
            sq_d.idx  = (sq_q.idx == LAST) ? '0 : sq_q.idx + 1'b1;
        end
        if (srst) begin
            sq_d.idx  = '0;
            sq_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        sq_q <= sq_d;
    end

    assign bank_bit = bank[sq_q.idx];
    assign done     = sq_q.done;

    p_idx_hold_r10: assert property (@(posedge clk) disable iff (srst)
        (!srst && !advance) |=> $stable(sq_q.idx));
    p_idx_range_r10: assert property (@(posedge clk) disable iff (srst)
        sq_q.idx <= LAST);
    p_done_once_r11: assert property (@(posedge clk) disable iff (srst)
        done |=> !done);
    p_done_cause_r11: assert property (@(posedge clk) disable iff (srst)
        done |-> ($past(advance) && sq_q.idx == '0));
    p_reset_idx_r12: assert property (@(posedge clk)
        srst |=> (sq_q.idx == '0 && !done));
endmodule

// File: rtl/audio_sample_formatter.sv
module audio_sample_formatter
    import fmt_pkg::*;
#(
    parameter int unsigned WORD_W  = 32,
    parameter int unsigned N_WORDS = 3
) (
    input  logic              clk,
    input  logic              srst,
    input  logic [1:0]        swap_mode,
    input  logic              user_sel,
    input  logic [WORD_W-1:0] user_w0,
    input  logic [WORD_W-1:0] user_w1,
    input  logic [WORD_W-1:0] user_w2,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [SMP_W-1:0]  in_sample,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [SMP_W-1:0]  out_sample,
    output logic              out_user,
    input  logic              sf_advance,
    output logic              ud_done
);
    localparam int unsigned BANK_W = N_WORDS * WORD_W;

    logic [SMP_W-1:0]  swapped;
    logic              top_q;
    logic              bank_bit;
    logic [BANK_W-1:0] bank;

    assign bank = {user_w2, user_w1, user_w0};

    fmt_byte_swap u_swap (
        .order   (swap_mode),
        .raw     (in_sample),
        .swapped (swapped)
    );

    fmt_sample_stage u_stage (
        .clk        (clk),
        .srst       (srst),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .fmt_sample (swapped),
        .raw_top    (in_sample[SMP_W-1]),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_sample (out_sample),
        .out_top    (top_q)
    );

    fmt_user_seq #(
        .WORD_W  (WORD_W),
        .N_WORDS (N_WORDS)
    ) u_seq (
        .clk      (clk),
        .srst     (srst),
        .bank     (bank),
        .advance  (sf_advance),
        .bank_bit (bank_bit),
        .done     (ud_done)
    );

    assign out_user = user_sel ? top_q : bank_bit;

    p_ready_free_r1: assert property (@(posedge clk) disable iff (srst)
        !out_valid |-> in_ready);
endmodule

// File: tb/audio_sample_formatter_tb_top.sv
module audio_sample_formatter_tb_top;
    logic        clk = 1'b0;
    logic        srst;
    logic [1:0]  swap_mode;
    logic        user_sel;
    logic [31:0] user_w0, user_w1, user_w2;
    logic        in_valid, in_ready;
    logic [23:0] in_sample;
    logic        out_valid, out_ready;
    logic [23:0] out_sample;
    logic        out_user, sf_advance, ud_done;

    int n_cmp = 0;
    int n_bad = 0;
    bit ended = 0;

    always #5 clk = ~clk;

    audio_sample_formatter dut_i (
        .clk(clk), .srst(srst), .swap_mode(swap_mode), .user_sel(user_sel),
        .user_w0(user_w0), .user_w1(user_w1), .user_w2(user_w2),
        .in_valid(in_valid), .in_ready(in_ready), .in_sample(in_sample),
        .out_valid(out_valid), .out_ready(out_ready), .out_sample(out_sample),
        .out_user(out_user), .sf_advance(sf_advance), .ud_done(ud_done)
    );

    function automatic logic [23:0] ref_swap(logic [1:0] m, logic [23:0] s);
        case (m)
            2'b10:   return {s[7:0], s[15:8], s[23:16]};
            2'b11:   return {8'h00, s[7:0], s[15:8]};
            default: return s;
        endcase
    endfunction

    function automatic logic ref_bank(int p);
        logic [95:0] b;
        b = {user_w2, user_w1, user_w0};
        return b[p];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // bench model state
    logic        m_valid;
    logic [23:0] m_sample;
    logic        m_top;
    int          m_idx;
    logic        m_done;
    logic [1:0]  m_mode;

    task automatic step_model();
        logic fire;
        fire = in_valid && (!m_valid || out_ready);
        if (srst) begin
            m_valid = 0; m_idx = 0; m_done = 0;
        end else begin
            m_done = sf_advance && (m_idx == 95);
            if (sf_advance) m_idx = (m_idx == 95) ? 0 : m_idx + 1;
            if (fire) begin
                m_valid = 1; m_sample = ref_swap(swap_mode, in_sample);
                m_top = in_sample[23]; m_mode = swap_mode;
            end else if (out_ready) begin
                m_valid = 0;
            end
        end
    endtask

    task automatic check_outputs(logic stalled, logic [23:0] prev_s);
        string sreq;
        check(m_valid ? "R6" : "R1", {31'd0, out_valid}, {31'd0, m_valid});
        if (m_valid) begin
            case (m_mode)
                2'b00: sreq = "R2";
                2'b01: sreq = "R3";
                2'b10: sreq = "R4";
                default: sreq = "R5";
            endcase
            check(sreq, {8'd0, out_sample}, {8'd0, m_sample});
            if (stalled) check("R7 hold", {8'd0, out_sample}, {8'd0, prev_s});
        end
        check("R11", {31'd0, ud_done}, {31'd0, m_done});
        if (!user_sel) check("R8", {31'd0, out_user}, {31'd0, ref_bank(m_idx)});
        else if (m_valid) check("R9", {31'd0, out_user}, {31'd0, m_top});
    endtask

    initial begin
        #1_500_000;
        if (!ended) begin
            ended = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        srst = 1; swap_mode = 0; user_sel = 0;
        user_w0 = 32'hA5C3_0F1E; user_w1 = 32'h1234_8765; user_w2 = 32'hF00D_BEEF;
        in_valid = 0; in_sample = 0; out_ready = 0; sf_advance = 0;
        m_valid = 0; m_idx = 0; m_done = 0; m_sample = 0; m_top = 0; m_mode = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 valid", {31'd0, out_valid}, 32'd0);
        check("R1 done", {31'd0, ud_done}, 32'd0);
        check("R1 ready", {31'd0, in_ready}, 32'd1);
        check("R1 user pos0", {31'd0, out_user}, {31'd0, user_w0[0]});
        srst = 0;

        for (int cyc = 0; cyc < 6000; cyc++) begin
            logic        stalled;
            logic [23:0] prev_s;
            stalled = out_valid && !out_ready;
            prev_s  = out_sample;
            @(negedge clk);
            check_outputs(stalled, prev_s);
            // new inputs
            srst       = (cyc == 3000 || cyc == 3001);   // R12 mid-sequence reset
            in_valid   = ($urandom % 4) != 0;
            in_sample  = 24'($urandom);
            out_ready  = ($urandom % 3) != 0;
            sf_advance = (cyc < 300) ? 1'b1 : (($urandom % 2) == 0);
            if (cyc % 50 == 0) swap_mode = 2'($urandom);
            if (cyc % 97 == 0) user_sel = 1'($urandom);
            if (cyc == 3002) user_sel = 0;
            #1;
            check("R7 ready", {31'd0, in_ready}, {31'd0, (!m_valid || out_ready)});
            if (cyc == 3002) check("R12 restart", {31'd0, out_user}, {31'd0, user_w0[0]});
            step_model();
        end
        @(negedge clk);
        check_outputs(1'b0, out_sample);
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule